// File: doc/BRIEF.md
# Flash Command Interpreter Model

This block is a synthesizable model of the command layer of a small NOR flash array. A host writes 16-bit command words through a single request channel and reads back either stored array words or a status byte. Which one comes back depends on the last mode-selecting command. Busy periods for word programming and block erase come from two countdown lengths applied on input pins. The array is a small register memory split into equal blocks, and each block has its own lock bit.

The block is meant as a partner for a flash sequencer under test. The sequencer can unlock a block, program words, erase a block, pause an erase to read other data, resume it, and poll the ready bit in the same way it would with a real device.

The request channel uses valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Each accepted read produces exactly one response, valid on the following cycle. A response is held with its data unchanged until `rsp_ready` is high. While a response is waiting and `rsp_ready` is low, `req_ready` stays low, so no further request of either kind is taken.

Top module: `nor_cmd_engine`

## Requirements
- R1: After reset every word holds 0xFFFF, every block is locked, reads return array data, and the status word is 0x0080.
- R2: Command 0x00FF selects array reads. Command 0x0070 selects status reads. The status word carries the following bits and zeros elsewhere: bit 7 ready, bit 6 erase suspended, bit 5 erase error, bit 4 program or sequence error, bit 1 locked-block error.
- R3: Command 0x0060 followed by 0x00D0 clears the lock of the block addressed by the second write. Lock bits never become set again after reset.
- R4: Command 0x0040 followed by a data write programs the addressed word to old AND data. For `prog_time` cycles after the data write, bit 7 is 0 and every read returns the status word.
- R5: Command 0x0020 followed by 0x00D0 erases the addressed block. After `erase_time` running cycles every word of that block is 0xFFFF. While the erase runs, bit 7 is 0 and reads return status.
- R6: Command 0x00B0 during a running erase freezes the erase countdown and gives status 0x00C0. If no erase is running, the command only selects status mode, and bit 6 stays 0.
- R7: Command 0x00D0 while suspended resumes the erase from the frozen count, clears bit 6 and selects status mode.
- R8: Command 0x0050 clears bits 5, 4 and 1 and leaves the read mode unchanged.
- R9: A program to a locked block sets bits 4 and 1. An erase of a locked block sets bits 5 and 1. In both cases the device does not go busy and the array is unchanged.
- R10: An unknown command, or a wrong second word after 0x0020 or 0x0060, sets bits 5 and 4 and selects status mode.
- R11: A read taken at one edge gives `rsp_valid` at the next edge. A response held by low `rsp_ready` keeps its data, and `req_ready` is low meanwhile.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_time | input | 16 | Program busy length in cycles |
| erase_time | input | 16 | Erase busy length in cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Word address (upper bits select block) |
| req_wdata | input | 16 | Command or data word |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 16 | Array word or status word |

## Verification
The hardest case to reach is a suspended erase that is shown to be really paused. The bench starts a long erase on a block that holds programmed data, then suspends it a few cycles later. It idles for longer than the full erase time and checks two things: that status still reads 0x00C0, and that the programmed word is still intact in array mode. Only after that does it resume the erase and poll until the block reads 0xFFFF. A later suspend on an idle device confirms that bit 6 stays clear.

// File: rtl/nor_pkg.sv
package nor_pkg;
  localparam logic [15:0] CMD_READ_ARRAY  = 16'h00FF;
  localparam logic [15:0] CMD_READ_STATUS = 16'h0070;
  localparam logic [15:0] CMD_CLEAR_ERR   = 16'h0050;
  localparam logic [15:0] CMD_PROGRAM     = 16'h0040;
  localparam logic [15:0] CMD_ERASE       = 16'h0020;
  localparam logic [15:0] CMD_CONFIRM     = 16'h00D0;
  localparam logic [15:0] CMD_SUSPEND     = 16'h00B0;
  localparam logic [15:0] CMD_LOCK_SETUP  = 16'h0060;

  typedef enum logic [1:0] {OP_IDLE, OP_PROG, OP_ERASE, OP_SUSP} op_e;
  typedef enum logic [1:0] {PD_NONE, PD_DATA, PD_ERASE, PD_UNLOCK} pend_e;
endpackage

// File: rtl/nor_op_timer.sv
module nor_op_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] len,
  input  logic          run,
  output logic [TW-1:0] cnt,
  output logic          done
);
  localparam logic [TW-1:0] ONE = {{(TW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= (len == '0) ? ONE : len;
    else if (run && cnt != '0) cnt <= cnt - ONE;
  end

  assign done = run && (cnt == ONE);
endmodule

// File: rtl/nor_array.sv
module nor_array #(
  parameter int BLOCKS = 4,
  parameter int WPB    = 8,
  parameter int DW     = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             prog_en,
  input  logic [$clog2(BLOCKS*WPB)-1:0]    prog_addr,
  input  logic [DW-1:0]                    prog_data,
  input  logic                             erase_en,
  input  logic [$clog2(BLOCKS)-1:0]        erase_blk,
  input  logic [$clog2(BLOCKS*WPB)-1:0]    rd_addr,
  output logic [DW-1:0]                    rd_data
);
  localparam int WORDS = BLOCKS * WPB;
  localparam int AW    = $clog2(WORDS);
  localparam int BW    = $clog2(BLOCKS);

  logic [DW-1:0] words [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam int BLK = w / WPB;
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        word_q <= '1;
      else if (erase_en && erase_blk == BW'(BLK))
        word_q <= '1;
      else if (prog_en && prog_addr == AW'(w))
        word_q <= word_q & prog_data;
    end
    assign words[w] = word_q;
  end

  assign rd_data = words[rd_addr];
endmodule

// File: rtl/nor_rsp_reg.sv
module nor_rsp_reg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] d,
  input  logic          rsp_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          can_accept
);
  assign can_accept = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_data  <= d;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine #(
  parameter int BLOCKS = 4,
  parameter int WPB    = 8,
  parameter int TW     = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [TW-1:0]                 prog_time,
  input  logic [TW-1:0]                 erase_time,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [$clog2(BLOCKS*WPB)-1:0] req_addr,
  input  logic [15:0]                   req_wdata,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [15:0]                   rsp_data
);
  import nor_pkg::*;

  localparam int AW = $clog2(BLOCKS*WPB);
  localparam int OW = $clog2(WPB);
  localparam int BW = $clog2(BLOCKS);

  op_e              op_q, op_d;
  pend_e            pend_q, pend_d;
  logic             stat_mode_q, stat_mode_d;
  logic             err_erase_q, err_erase_d;
  logic             err_prog_q, err_prog_d;
  logic             err_lock_q, err_lock_d;
  logic [BLOCKS-1:0] locks_q, locks_d;
  logic [AW-1:0]    tgt_addr_q, tgt_addr_d;
  logic [15:0]      tgt_data_q, tgt_data_d;

  logic          wr_fire, rd_fire, busy, tmr_load, tmr_done, tgt_locked;
  logic [TW-1:0] tmr_len, tmr_cnt;
  logic [BW-1:0] wr_blk;
  logic [15:0]   status_w, arr_rd, rd_word;

  assign wr_fire    = req_valid && req_ready && req_write;
  assign rd_fire    = req_valid && req_ready && !req_write;
  assign busy       = (op_q == OP_PROG) || (op_q == OP_ERASE);
  assign wr_blk     = req_addr[AW-1:OW];
  assign tgt_locked = locks_q[wr_blk];

  nor_op_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(tmr_len),
    .run(busy), .cnt(tmr_cnt), .done(tmr_done)
  );

  nor_array #(.BLOCKS(BLOCKS), .WPB(WPB), .DW(16)) u_array (
    .clk(clk), .rst_n(rst_n),
    .prog_en(tmr_done && op_q == OP_PROG), .prog_addr(tgt_addr_q), .prog_data(tgt_data_q),
    .erase_en(tmr_done && op_q == OP_ERASE), .erase_blk(tgt_addr_q[AW-1:OW]),
    .rd_addr(req_addr), .rd_data(arr_rd)
  );

  assign status_w = {8'h00, !busy, op_q == OP_SUSP, err_erase_q, err_prog_q,
                     2'b00, err_lock_q, 1'b0};
  assign rd_word  = (stat_mode_q || busy) ? status_w : arr_rd;

  nor_rsp_reg #(.DW(16)) u_rsp (
    .clk(clk), .rst_n(rst_n), .load(rd_fire), .d(rd_word),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .can_accept(req_ready)
  );

  always_comb begin
    op_d        = op_q;
    pend_d      = pend_q;
    stat_mode_d = stat_mode_q;
    err_erase_d = err_erase_q;
    err_prog_d  = err_prog_q;
    err_lock_d  = err_lock_q;
    locks_d     = locks_q;
    tgt_addr_d  = tgt_addr_q;
    tgt_data_d  = tgt_data_q;
    tmr_load    = 1'b0;
    tmr_len     = prog_time;
    if (tmr_done) op_d = OP_IDLE;
    if (wr_fire) begin
      if (busy) begin
        if (req_wdata == CMD_SUSPEND && op_q == OP_ERASE && !tmr_done) begin
          op_d        = OP_SUSP;
          stat_mode_d = 1'b1;
        end else if (req_wdata == CMD_READ_STATUS) begin
          stat_mode_d = 1'b1;
        end
      end else if (pend_q != PD_NONE) begin
        pend_d = PD_NONE;
        case (pend_q)
          PD_DATA: begin
            stat_mode_d = 1'b1;
            if (tgt_locked) begin
              err_prog_d = 1'b1;
              err_lock_d = 1'b1;
            end else begin
              op_d       = OP_PROG;
              tgt_addr_d = req_addr;
              tgt_data_d = req_wdata;
              tmr_load   = 1'b1;
            end
          end
          PD_ERASE: begin
            stat_mode_d = 1'b1;
            if (req_wdata != CMD_CONFIRM) begin
              err_prog_d  = 1'b1;
              err_erase_d = 1'b1;
            end else if (tgt_locked) begin
              err_erase_d = 1'b1;
              err_lock_d  = 1'b1;
            end else begin
              op_d       = OP_ERASE;
              tgt_addr_d = req_addr;
              tmr_len    = erase_time;
              tmr_load   = 1'b1;
            end
          end
          PD_UNLOCK: begin
            if (req_wdata == CMD_CONFIRM) begin
              locks_d[wr_blk] = 1'b0;
            end else begin
              err_prog_d  = 1'b1;
              err_erase_d = 1'b1;
              stat_mode_d = 1'b1;
            end
          end
          default: ;
        endcase
      end else begin
        case (req_wdata)
          CMD_READ_ARRAY:  stat_mode_d = 1'b0;
          CMD_READ_STATUS: stat_mode_d = 1'b1;
          CMD_SUSPEND:     stat_mode_d = 1'b1;
          CMD_CLEAR_ERR: begin
            err_erase_d = 1'b0;
            err_prog_d  = 1'b0;
            err_lock_d  = 1'b0;
          end
          CMD_CONFIRM: begin
            stat_mode_d = 1'b1;
            if (op_q == OP_SUSP) op_d = OP_ERASE;
            else begin
              err_prog_d  = 1'b1;
              err_erase_d = 1'b1;
            end
          end
          CMD_PROGRAM, CMD_ERASE, CMD_LOCK_SETUP: begin
            if (op_q == OP_SUSP) begin
              err_prog_d  = 1'b1;
              err_erase_d = 1'b1;
              stat_mode_d = 1'b1;
            end else if (req_wdata == CMD_PROGRAM) begin
              pend_d      = PD_DATA;
              stat_mode_d = 1'b1;
            end else if (req_wdata == CMD_ERASE) begin
              pend_d      = PD_ERASE;
              stat_mode_d = 1'b1;
            end else begin
              pend_d = PD_UNLOCK;
            end
          end
          default: begin
            err_prog_d  = 1'b1;
            err_erase_d = 1'b1;
            stat_mode_d = 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q        <= OP_IDLE;
      pend_q      <= PD_NONE;
      stat_mode_q <= 1'b0;
      err_erase_q <= 1'b0;
      err_prog_q  <= 1'b0;
      err_lock_q  <= 1'b0;
      locks_q     <= '1;
      tgt_addr_q  <= '0;
      tgt_data_q  <= '0;
    end else begin
      op_q        <= op_d;
      pend_q      <= pend_d;
      stat_mode_q <= stat_mode_d;
      err_erase_q <= err_erase_d;
      err_prog_q  <= err_prog_d;
      err_lock_q  <= err_lock_d;
      locks_q     <= locks_d;
      tgt_addr_q  <= tgt_addr_d;
      tgt_data_q  <= tgt_data_d;
    end
  end
endmodule

// File: rtl/nor_cmd_engine_checker.sv
module nor_cmd_engine_checker #(
  parameter int BLOCKS = 4,
  parameter int TW     = 16
) (
  input logic              clk,
  input logic              rst_n,
  input nor_pkg::op_e      op_q,
  input nor_pkg::pend_e    pend_q,
  input logic [TW-1:0]     tmr_cnt,
  input logic              tmr_done,
  input logic [BLOCKS-1:0] locks_q,
  input logic              wr_fire,
  input logic              tgt_locked,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [15:0]       rsp_data
);
  import nor_pkg::*;

  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid); // R11
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R11
  AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_SUSP) |=> $stable(tmr_cnt)); // R6
  AST_DONE_ENDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_done |=> (op_q == OP_IDLE)); // R4
  AST_BUSY_HAS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_PROG || op_q == OP_ERASE) |-> (tmr_cnt != '0)); // R5
  AST_LOCKED_NO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && pend_q == PD_DATA && tgt_locked) |=> (op_q == OP_IDLE)); // R9
  AST_LOCKS_ONLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((locks_q & ~$past(locks_q)) == '0)); // R3
endmodule

bind nor_cmd_engine nor_cmd_engine_checker #(.BLOCKS(BLOCKS), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_q(op_q), .pend_q(pend_q), .tmr_cnt(tmr_cnt),
  .tmr_done(tmr_done), .locks_q(locks_q), .wr_fire(wr_fire), .tgt_locked(tgt_locked),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
);

// File: tb/nor_cmd_engine_test.sv
module nor_cmd_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] prog_time = 16'd5;
  logic [15:0] erase_time = 16'd40;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [4:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_data;

  int checks = 0, fails = 0;
  logic [16:0] expq[$];
  string       tagq[$];
  logic [15:0] last_rsp;

  always #10 clk = ~clk;

  nor_cmd_engine uut (
    .clk(clk), .rst_n(rst_n), .prog_time(prog_time), .erase_time(erase_time),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as responses are taken
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (expq.size() == 0) begin
        check("R11 unexpected response", rsp_data, 16'hxxxx);
      end else begin
        logic [16:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        last_rsp = rsp_data;
        if (e[16]) check(t, rsp_data, e[15:0]);
      end
    end
  end

  task automatic bus(input logic wr, input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    bus(1'b1, a, d);
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
    expq.push_back({1'b1, exp});
    tagq.push_back(tag);
    bus(1'b0, a, 16'h0);
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
  endtask

  task automatic poll_ready();
    for (int i = 0; i < 200; i++) begin
      expq.push_back({1'b0, 16'h0});
      tagq.push_back("poll");
      bus(1'b0, 5'd0, 16'h0);
      drain();
      if (last_rsp[7]) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got hang expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(5'd0, 16'hFFFF, "R1 reset array");
    wr(5'd0, 16'h0070);
    rd(5'd0, 16'h0080, "R1 R2 reset status");
    // R9 program into locked block 1
    wr(5'd9, 16'h0040); wr(5'd9, 16'h0000);
    rd(5'd9, 16'h0092, "R9 locked program status");
    wr(5'd0, 16'h00FF);
    rd(5'd9, 16'hFFFF, "R9 R2 locked word unchanged");
    // R8 clear keeps mode
    wr(5'd0, 16'h0050);
    rd(5'd9, 16'hFFFF, "R8 clear keeps array mode");
    wr(5'd0, 16'h0070);
    rd(5'd0, 16'h0080, "R8 errors cleared");
    // R3 unlock block 0, R4 program
    wr(5'd0, 16'h0060); wr(5'd0, 16'h00D0);
    wr(5'd3, 16'h0040); wr(5'd3, 16'h1234);
    rd(5'd3, 16'h0000, "R4 busy status");
    drain(); poll_ready();
    wr(5'd0, 16'h00FF);
    rd(5'd3, 16'h1234, "R3 R4 programmed word");
    wr(5'd3, 16'h0040); wr(5'd3, 16'hFF0F);
    drain(); poll_ready();
    wr(5'd0, 16'h00FF);
    rd(5'd3, 16'h1204, "R4 program ANDs");
    rd(5'd4, 16'hFFFF, "R4 neighbour untouched");
    // R5/R6/R7 erase with suspend
    wr(5'd0, 16'h0020); wr(5'd0, 16'h00D0);
    rd(5'd0, 16'h0000, "R5 erase busy");
    wr(5'd0, 16'h00B0);
    rd(5'd0, 16'h00C0, "R6 suspended status");
    repeat (60) @(posedge clk);
    rd(5'd0, 16'h00C0, "R6 still suspended");
    wr(5'd0, 16'h00FF);
    rd(5'd3, 16'h1204, "R6 erase paused");
    wr(5'd0, 16'h00D0);
    rd(5'd0, 16'h0000, "R7 resumed busy");
    drain(); poll_ready();
    wr(5'd0, 16'h00FF);
    rd(5'd3, 16'hFFFF, "R5 block erased");
    rd(5'd7, 16'hFFFF, "R5 block erased last");
    wr(5'd0, 16'h00B0);
    rd(5'd0, 16'h0080, "R6 suspend when idle");
    // R10 sequence errors
    wr(5'd0, 16'h00FF); wr(5'd0, 16'h0033);
    rd(5'd0, 16'h00B0, "R10 unknown command");
    wr(5'd0, 16'h0050);
    wr(5'd0, 16'h0020); wr(5'd0, 16'h0055);
    rd(5'd0, 16'h00B0, "R10 bad erase confirm");
    wr(5'd0, 16'h0050);
    // R9 erase of locked block
    wr(5'd8, 16'h0020); wr(5'd8, 16'h00D0);
    rd(5'd8, 16'h00A2, "R9 locked erase status");
    wr(5'd0, 16'h0050);
    drain();
    // R11 back-pressure
    @(negedge clk); rsp_ready = 1'b0;
    rd(5'd0, 16'h0080, "R11 held response");
    repeat (3) @(negedge clk);
    check("R11 valid held", {15'd0, rsp_valid}, 16'd1);
    check("R11 ready low", {15'd0, req_ready}, 16'd0);
    check("R11 data held", rsp_data, 16'h0080);
    rsp_ready = 1'b1;
    drain();
    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule